// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the ROM-function layer of one slave on a 1-Wire bus. A bit-slot layer underneath it converts the line waveform into single-cycle events. These events are a bus reset that the slave has already answered with its presence pulse, a bit the master has written, and the start of a read slot. The block holds a fixed 64-bit identity. Bits 7:0 are the family code, bits 55:8 are the serial number and bits 63:56 are the check byte. After every bus reset the block collects an 8-bit command and then runs the matching ROM function.

There are five ROM functions. Read ROM transmits the identity. Match ROM compares the identity against 64 bits sent by the master. Skip ROM selects the slave at once. Search ROM and Alarm Search take part in bitwise arbitration: for each bit the slave sends the bit, then its complement, and then reads the direction the master chose. The block's only line output is a request to pull the open-drain bus low during the current read slot. When the request is low the line is released, so several slaves answering together form a wired AND.

A `selected_o` flag enables the memory-function layer downstream once a ROM function ends with this slave addressed. The analog slot timing, the check-byte generator and the temperature logic that produces the alarm flag are outside this block.

Top module: `owr_rom_layer`

## Requirements
- R1: After the synchronous reset `rst`, `pull_low_o` and `selected_o` are 0 and the block waits for a command byte.
- R2: A `bus_reset_i` pulse in any state aborts the current function. In the following cycle `selected_o` and `pull_low_o` are 0, and the next 8 written bits form a new command.
- R3: Command bits arrive least-significant first. Skip ROM (0xCC) raises `selected_o` one cycle after the eighth command bit, and while selected the bus is never pulled low.
- R4: Read ROM (0x33) answers 64 read slots with identity bits 0 to 63 in order, where `pull_low_o` is 1 exactly when the bit is 0. `selected_o` rises one cycle after the 64th slot.
- R5: Match ROM (0x55) raises `selected_o` one cycle after the 64th written bit when bit i of the written stream equals identity bit i for every i. Once selected, the slave stays selected until a bus reset.
- R6: During Match ROM, a written bit that differs from the identity leaves the slave unselected and releasing the bus until the next bus reset.
- R7: Search ROM (0xF0) handles each identity bit in three steps: the first read slot carries the bit, the second carries its complement, and then a written bit is compared with it. When all 64 comparisons agree, `selected_o` rises one cycle after the last written bit.
- R8: During Search ROM, a written direction bit that differs from the slave's identity bit makes the slave release the bus and stay unselected until the next bus reset.
- R9: Alarm Search (0xEC) behaves exactly like Search ROM when `alarm_i` is 1 at the moment the command is decoded. Otherwise the slave never pulls the bus low and stays unselected until the next bus reset.
- R10: Any other command value leaves the slave unselected, with the bus released, until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle pulse: the master issued a bus reset |
| wr_valid_i | input | 1 | One-cycle pulse: a written bit was received |
| wr_bit_i | input | 1 | Value of the written bit, valid with `wr_valid_i` |
| rd_slot_i | input | 1 | One-cycle pulse: the current read slot is complete |
| alarm_i | input | 1 | Alarm condition from the last measurement |
| pull_low_o | output | 1 | Request to pull the bus low during the current read slot |
| selected_o | output | 1 | Slave addressed; enables the memory-function layer |

## Verification
Every result is due in the cycle after the input pulse that causes it. This applies to a command decode, an identity bit advancing after a read slot, a search step advancing, and `selected_o` rising after the last bit. The outputs depend only on registers, so the bench drives each pulse at a falling edge and compares both outputs at the next falling edge, after exactly one rising edge has passed. For this comparison a behavioural model in the bench updates on each rising edge. The value the slave offers in a read slot is sampled in the cycle before the slot pulse, which is when the line would be sensed.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_SEL,
    ST_PARK
  } st_e;

  typedef enum logic [1:0] {
    PH_TRUE,
    PH_CMPL,
    PH_DIR
  } ph_e;

  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
  localparam logic [7:0] OP_ALARM  = 8'hEC;
endpackage

// File: rtl/owr_bit_ctr.sv
module owr_bit_ctr #(
  parameter int COUNT = 64,
  parameter int CW    = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = (cnt == CW'(COUNT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/owr_cmd_shift.sv
module owr_cmd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] word_nxt,
  output logic         done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr;
  logic [CW-1:0] n_bits;
  logic          at_last;

  owr_bit_ctr #(.COUNT(W), .CW(CW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .step (shift),
    .cnt  (n_bits),
    .last (at_last)
  );

  // LSB arrives first, so each new bit enters at the top and slides down
  assign word_nxt = {din, sr[W-1:1]};
  assign done     = shift && at_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr <= '0;
    end else if (shift) begin
      sr <= word_nxt;
    end
  end
endmodule

// File: rtl/owr_rom_sel.sv
module owr_rom_sel #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  rom,
  input  logic [IW-1:0] idx,
  output logic          bit_o
);
  assign bit_o = rom[idx];
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
  import owr_rom_pkg::*;
#(
  parameter int               ROM_W  = 64,
  parameter logic [ROM_W-1:0] ROM_ID = 64'h9E00_0801_2345_6710,
  parameter int               CMD_W  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_reset_i,
  input  logic wr_valid_i,
  input  logic wr_bit_i,
  input  logic rd_slot_i,
  input  logic alarm_i,
  output logic pull_low_o,
  output logic selected_o
);
  localparam int IW = (ROM_W > 1) ? $clog2(ROM_W) : 1;

  st_e st, st_n;
  ph_e ph, ph_n;

  logic [CMD_W-1:0] cmd_word;
  logic             cmd_done;
  logic [IW-1:0]    idx;
  logic             idx_last;
  logic             cur_bit;
  logic             idx_step;
  logic             dir_ok;
  logic             sel_q;

  owr_cmd_shift #(.W(CMD_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .clr      (bus_reset_i),
    .shift    (wr_valid_i && !bus_reset_i && (st == ST_CMD)),
    .din      (wr_bit_i),
    .word_nxt (cmd_word),
    .done     (cmd_done)
  );

  owr_bit_ctr #(.COUNT(ROM_W), .CW(IW)) u_idx (
    .clk  (clk),
    .rst  (rst),
    .clr  (bus_reset_i || cmd_done),
    .step (idx_step),
    .cnt  (idx),
    .last (idx_last)
  );

  owr_rom_sel #(.N(ROM_W), .IW(IW)) u_sel (
    .rom   (ROM_ID),
    .idx   (idx),
    .bit_o (cur_bit)
  );

  assign dir_ok   = (wr_bit_i == cur_bit);
  assign idx_step = ((st == ST_READ) && rd_slot_i) ||
                    ((st == ST_MATCH) && wr_valid_i && dir_ok) ||
                    ((st == ST_SEARCH) && (ph == PH_DIR) && wr_valid_i && dir_ok);

  always_comb begin
    st_n = st;
    ph_n = ph;
    if (bus_reset_i) begin
      st_n = ST_CMD;
      ph_n = PH_TRUE;
    end else begin
      case (st)
        ST_CMD: begin
          if (cmd_done) begin
            ph_n = PH_TRUE;
            if (cmd_word == CMD_W'(OP_READ))        st_n = ST_READ;
            else if (cmd_word == CMD_W'(OP_MATCH))  st_n = ST_MATCH;
            else if (cmd_word == CMD_W'(OP_SKIP))   st_n = ST_SEL;
            else if (cmd_word == CMD_W'(OP_SEARCH)) st_n = ST_SEARCH;
            else if (cmd_word == CMD_W'(OP_ALARM))  st_n = alarm_i ? ST_SEARCH : ST_PARK;
            else                                    st_n = ST_PARK;
          end
        end
        ST_READ: begin
          if (rd_slot_i && idx_last) st_n = ST_SEL;
        end
        ST_MATCH: begin
          if (wr_valid_i) begin
            if (!dir_ok)       st_n = ST_PARK;
            else if (idx_last) st_n = ST_SEL;
          end
        end
        ST_SEARCH: begin
          case (ph)
            PH_TRUE: if (rd_slot_i) ph_n = PH_CMPL;
            PH_CMPL: if (rd_slot_i) ph_n = PH_DIR;
            default: begin
              if (wr_valid_i) begin
                ph_n = PH_TRUE;
                if (!dir_ok)       st_n = ST_PARK;
                else if (idx_last) st_n = ST_SEL;
              end
            end
          endcase
        end
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_CMD;
      ph    <= PH_TRUE;
      sel_q <= 1'b0;
    end else begin
      st    <= st_n;
      ph    <= ph_n;
      sel_q <= (st_n == ST_SEL);
    end
  end

  // Decoded from registers only: no path from an input pin to the line request
  always_comb begin
    pull_low_o = 1'b0;
    if (st == ST_READ) begin
      pull_low_o = !cur_bit;
    end else if (st == ST_SEARCH) begin
      if (ph == PH_TRUE)      pull_low_o = !cur_bit;
      else if (ph == PH_CMPL) pull_low_o = cur_bit;
    end
  end

  assign selected_o = sel_q;
endmodule

// File: rtl/owr_rom_checker.sv
module owr_rom_checker (
  input logic clk,
  input logic rst,
  input logic bus_reset_i,
  input logic wr_valid_i,
  input logic rd_slot_i,
  input logic pull_low_o,
  input logic selected_o
);
  p_bus_reset_clears_r2: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> (!selected_o && !pull_low_o));

  p_sel_releases_bus_r3: assert property (@(posedge clk) disable iff (rst)
    selected_o |-> !pull_low_o);

  p_sel_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (selected_o && !bus_reset_i) |=> selected_o);

  p_sel_rise_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(selected_o) |-> $past(wr_valid_i || rd_slot_i));
endmodule

bind owr_rom_layer owr_rom_checker u_chk (.*);

// File: tb/sim_owr_rom_layer.sv
`timescale 1ns/1ps
module sim_owr_rom_layer;
  localparam logic [63:0] ID = 64'h9E00_0801_2345_6710;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset = 1'b0, wr_valid = 1'b0, wr_bit = 1'b0, rd_slot = 1'b0, alarm = 1'b0;
  logic pull_low, selected;

  always #2.5 clk = ~clk;

  owr_rom_layer #(.ROM_W(64), .ROM_ID(ID), .CMD_W(8)) u0 (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset), .wr_valid_i(wr_valid),
    .wr_bit_i(wr_bit), .rd_slot_i(rd_slot), .alarm_i(alarm),
    .pull_low_o(pull_low), .selected_o(selected)
  );

  int n_vec = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";

  // Behavioural model: mode 0 command, 1 read, 2 match, 3 search, 4 selected, 5 parked
  int mode = 0, pos = 0, sub = 0, ccount = 0;
  logic [7:0] cbyte = 8'h00;
  logic exp_pull, exp_sel;

  always @(posedge clk) begin
    if (rst || bus_reset) begin
      mode = 0; pos = 0; sub = 0; ccount = 0; cbyte = 8'h00;
    end else if (mode == 0) begin
      if (wr_valid) begin
        cbyte[ccount] = wr_bit;
        ccount++;
        if (ccount == 8) begin
          ccount = 0; pos = 0; sub = 0;
          case (cbyte)
            8'h33: mode = 1;
            8'h55: mode = 2;
            8'hCC: mode = 4;
            8'hF0: mode = 3;
            8'hEC: mode = alarm ? 3 : 5;
            default: mode = 5;
          endcase
        end
      end
    end else if (mode == 1) begin
      if (rd_slot) begin pos++; if (pos == 64) mode = 4; end
    end else if (mode == 2) begin
      if (wr_valid) begin
        if (wr_bit != ID[pos]) mode = 5;
        else begin pos++; if (pos == 64) mode = 4; end
      end
    end else if (mode == 3) begin
      if (sub < 2) begin
        if (rd_slot) sub++;
      end else if (wr_valid) begin
        sub = 0;
        if (wr_bit != ID[pos]) mode = 5;
        else begin pos++; if (pos == 64) mode = 4; end
      end
    end
  end

  always_comb begin
    exp_sel  = (mode == 4);
    exp_pull = 1'b0;
    if (mode == 1 && pos < 64) exp_pull = !ID[pos];
    if (mode == 3 && pos < 64) exp_pull = (sub == 0) ? !ID[pos] : (sub == 1) ? ID[pos] : 1'b0;
  end

  always @(negedge clk) begin
    cycles++;
    n_vec++;
    if (pull_low !== exp_pull || selected !== exp_sel) begin
      n_bad++;
      $display("FAIL %s cycle %0d: pull_low/selected actual %b%b expected %b%b",
               cur_req, cycles, pull_low, selected, exp_pull, exp_sel);
    end
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_rst();
    @(negedge clk) bus_reset = 1'b1;
    @(negedge clk) bus_reset = 1'b0;
  endtask

  task automatic wbit(input logic b);
    @(negedge clk) begin wr_valid = 1'b1; wr_bit = b; end
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wbit(c[i]);
  endtask

  // Returns the line level the slave leaves during the slot (1 = released)
  task automatic rslot(output logic seen);
    @(negedge clk) begin seen = !pull_low; rd_slot = 1'b1; end
    @(negedge clk) rd_slot = 1'b0;
  endtask

  initial begin
    logic s0, s1;
    logic [63:0] got, cmp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {62'd0, pull_low, selected}, 64'd0);

    cur_req = "R3";
    bus_rst(); send_cmd(8'hCC);
    check("R3", selected, 1);
    rslot(s0); check("R3", s0, 1);

    cur_req = "R4";
    bus_rst(); check("R2", selected, 0);
    send_cmd(8'h33);
    for (int i = 0; i < 64; i++) begin rslot(s0); got[i] = s0; end
    check("R4", got, ID);
    check("R4", selected, 1);

    cur_req = "R5";
    bus_rst(); send_cmd(8'h55);
    for (int i = 0; i < 64; i++) wbit(ID[i]);
    check("R5", selected, 1);

    cur_req = "R6";
    bus_rst(); send_cmd(8'h55);
    for (int i = 0; i < 64; i++) wbit((i == 40) ? !ID[i] : ID[i]);
    check("R6", selected, 0);
    rslot(s0); check("R6", s0, 1);

    cur_req = "R7";
    bus_rst(); send_cmd(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rslot(s0); rslot(s1); got[i] = s0; cmp[i] = s1; wbit(ID[i]);
    end
    check("R7", got, ID);
    check("R7", cmp, ~ID);
    check("R7", selected, 1);

    cur_req = "R8";
    bus_rst(); send_cmd(8'hF0);
    for (int i = 0; i < 6; i++) begin
      rslot(s0); rslot(s1); wbit((i == 5) ? !ID[i] : ID[i]);
    end
    rslot(s0); rslot(s1);
    check("R8", {s0, s1}, 2'b11);
    check("R8", selected, 0);

    cur_req = "R9";
    alarm = 1'b0;
    bus_rst(); send_cmd(8'hEC);
    rslot(s0); rslot(s1);
    check("R9", {s0, s1}, 2'b11);
    wbit(ID[0]);
    check("R9", selected, 0);
    alarm = 1'b1;
    bus_rst(); send_cmd(8'hEC);
    for (int i = 0; i < 64; i++) begin
      rslot(s0); rslot(s1); got[i] = s0; cmp[i] = s1; wbit(ID[i]);
    end
    check("R9", got, ID);
    check("R9", selected, 1);
    alarm = 1'b0;

    cur_req = "R10";
    bus_rst(); send_cmd(8'hA5);
    check("R10", selected, 0);
    rslot(s0); check("R10", s0, 1);

    cur_req = "R2";
    bus_rst(); send_cmd(8'h33);
    for (int i = 0; i < 10; i++) rslot(s0);
    bus_rst();
    check("R2", {62'd0, pull_low, selected}, 64'd0);
    send_cmd(8'hCC);
    check("R2", selected, 1);
    bus_rst();
    check("R2", selected, 0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule